// File: doc/BRIEF.md
# Prescaled Watchdog Counter

This block guards a processor against a stalled program. A long prescaler divides the system clock and advances an 8-bit up-counter. Each time software sends a refresh, the counter is loaded from a reload register. If no refresh arrives before the counter reaches its top value, the block raises a sticky timeout flag. When reset generation is enabled, it also drives a fixed-length internal reset pulse. After a timeout the counter restarts by itself from the reload value.

Software reaches the block through a small register write port. Address 0 is the control register: bit 0 enables the reset and bit 1 clears the flag when written as 1. Address 1 is the reload register. A one-cycle refresh strobe restarts the interval. A one-cycle idle strobe pauses all counting, and a one-cycle wake strobe, raised on an interrupt exit from idle, lets counting continue.

Top module: `prescaled_watchdog`

## Requirements
- R1: After `rst_n` is released, `wdt_flag` and `wdt_reset` are 0, the reload value is 0 and reset generation is off. With no refresh, the first timeout therefore comes 255×PRESCALE clocks after release and produces no reset pulse.
- R2: The prescaler emits one tick every PRESCALE clocks. A timeout happens on the tick that brings the counter to 255. `wdt_flag` rises exactly (255 − reload)×PRESCALE clocks after a refresh. A reload value of 255 is a special case and times out after PRESCALE clocks.
- R3: A refresh loads the counter from the reload register and clears the prescaler. Refreshing more often than the timeout period keeps `wdt_flag` at 0.
- R4: When control bit 0 is 1, a timeout drives `wdt_reset` high in the same cycle that `wdt_flag` rises, and keeps it high for exactly RST_LEN clocks.
- R5: When control bit 0 is 0, a timeout sets `wdt_flag` only, and `wdt_reset` stays 0.
- R6: `wdt_flag` is set by every timeout. It stays set through the block's own reset pulse and until software clears it.
- R7: A control write with bit 1 equal to 1 clears `wdt_flag`. A control write with bit 1 equal to 0 leaves it unchanged.
- R8: An `idle` strobe freezes the prescaler and the counter. A `wake` strobe resumes them. The timeout is delayed by exactly the number of frozen clocks.
- R9: Writing the reload register (address 1) during an interval does not change the running count. The new value takes effect at the next refresh or timeout restart.
- R10: After a timeout the counter restarts from the reload value with a cleared prescaler. The next timeout therefore follows one full period later.
- R11: Asserting `rst_n` clears a set `wdt_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the time base |
| rst_n | input | 1 | Active-low power-on/external reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = reload register |
| reg_wdata | input | 8 | Write data |
| refresh | input | 1 | Restart the interval from the reload value |
| idle | input | 1 | Strobe: enter idle, freeze counting |
| wake | input | 1 | Strobe: interrupt exit from idle, resume counting |
| wdt_flag | output | 1 | Sticky timeout flag |
| wdt_reset | output | 1 | Internal reset pulse |

## Verification
The bench builds the block with PRESCALE = 8 and RST_LEN = 4, so one counter step takes eight clocks. This brings a full 255-step timeout from reset, and several shorter ones, within a few thousand cycles. Each period can then be measured to the exact clock, as can the four-clock reset pulse, the idle freeze and the deferred reload.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] CNT_TOP = 8'd255;

  typedef enum logic {REG_CTRL = 1'b0, REG_RELOAD = 1'b1} wdg_reg_e;

  // control register bit positions
  localparam int CTRL_RST_EN = 0;
  localparam int CTRL_FLAG_CLR = 1;

  // true when the next tick makes the count reach the top value
  function automatic logic is_final_step(input logic [CNT_W-1:0] cnt);
    return cnt >= (CNT_TOP - 8'd1);
  endfunction

  // number of clocks from refresh to timeout
  function automatic int timeout_clocks(input logic [CNT_W-1:0] reload, input int prescale);
    int steps;
    steps = int'(CNT_TOP) - int'(reload);
    if (steps < 1) steps = 1;
    return steps * prescale;
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PRESCALE = 344064
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hold,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] count;

  assign tick = !hold && (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (clear)      count <= '0;
    else if (hold)       count <= count;
    else if (tick)       count <= '0;
    else                 count <= count + 1'b1;
  end

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !clear |=> $stable(count));
  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == '0);
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_req,
  input  logic [CNT_W-1:0] load_val,
  output logic             ovf
);
  logic [CNT_W-1:0] count;
  logic             load;

  // a refresh in the same cycle wins over a timeout
  assign ovf  = tick && is_final_step(count) && !load_req;
  assign load = load_req || ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (load)   count <= load_val;
    else if (tick)   count <= count + 1'b1;
  end

  // R3
  reload_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> count == $past(load_val));
  // R10
  ovf_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> count == $past(load_val));
  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !load_req |=> $stable(count));
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
  parameter int RST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] remain;

  assign active = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       remain <= '0;
    else if (fire)    remain <= CW'(RST_LEN);
    else if (active)  remain <= remain - 1'b1;
  end

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active);
  // R4
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> !$past(fire));
endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog
  import wdg_pkg::*;
#(
  parameter int PRESCALE = 344064,
  parameter int RST_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       refresh,
  input  logic       idle,
  input  logic       wake,
  output logic       wdt_flag,
  output logic       wdt_reset
);
  logic             rst_en_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             idle_q;
  logic             tick;
  logic             ovf;
  logic             restart;
  logic             wr_ctrl;
  logic             wr_reload;
  logic             flag_clr;

  assign wr_ctrl   = reg_we && (wdg_reg_e'(reg_addr) == REG_CTRL);
  assign wr_reload = reg_we && (wdg_reg_e'(reg_addr) == REG_RELOAD);
  assign flag_clr  = wr_ctrl && reg_wdata[CTRL_FLAG_CLR];
  assign restart   = refresh || ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en_q <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl)   rst_en_q <= reg_wdata[CTRL_RST_EN];
      if (wr_reload) reload_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (ovf)       flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idle_q <= 1'b0;
    else if (wake)  idle_q <= 1'b0;
    else if (idle)  idle_q <= 1'b1;
  end

  wdg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(restart), .hold(idle_q), .tick(tick)
  );

  wdg_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_req(refresh),
    .load_val(reload_q), .ovf(ovf)
  );

  wdg_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(ovf && rst_en_q), .active(wdt_reset)
  );

  assign wdt_flag = flag_q;

  // R5
  rst_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_reset) |-> $past(rst_en_q));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !flag_clr |=> flag_q);
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q);
endmodule

// File: tb/prescaled_watchdog_test.sv
`timescale 1ns/1ps
module prescaled_watchdog_test;
  localparam int P = 8;
  localparam int RL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic refresh = 1'b0;
  logic idle = 1'b0;
  logic wake = 1'b0;
  logic wdt_flag, wdt_reset;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prescaled_watchdog #(.PRESCALE(P), .RST_LEN(RL)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .refresh(refresh), .idle(idle), .wake(wake),
    .wdt_flag(wdt_flag), .wdt_reset(wdt_reset)
  );

  function automatic int period_of(input int reload);
    if (reload == 255) return P;
    return (255 - reload) * P;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [7:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = addr; reg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // refresh and clear flag in one cycle; leaves caller at negedge after that edge
  task automatic restart(input bit en);
    @(negedge clk);
    refresh = 1'b1; reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = {6'd0, 1'b1, en};
    @(posedge clk);
    @(negedge clk);
    refresh = 1'b0; reg_we = 1'b0;
  endtask

  task automatic count_to_flag(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      reg_we = 1'b0; refresh = 1'b0;
      if (wdt_flag) break;
    end
  endtask

  task automatic t_reset_state();
    int n;
    bit saw_rst = 1'b0;
    // R1
    check(wdt_flag == 1'b0, "R1 flag after reset", wdt_flag, 0);
    check(wdt_reset == 1'b0, "R1 reset out after reset", wdt_reset, 0);
    n = 0;
    while (n < 3000) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (wdt_reset) saw_rst = 1'b1;
      if (wdt_flag) break;
    end
    check(n == 255 * P, "R1 first timeout from reset", n, 255 * P);
    check(!saw_rst, "R5 no reset pulse with enable off", saw_rst, 0);
  endtask

  task automatic t_period(input int reload);
    int n;
    wr(1'b1, 8'(reload));
    restart(1'b0);
    count_to_flag(5000, n);
    // R2
    check(n == period_of(reload), "R2 timeout period", n, period_of(reload));
  endtask

  task automatic t_refresh_keeps();
    bit seen = 1'b0;
    wr(1'b1, 8'd250);
    restart(1'b0);
    for (int k = 0; k < 6; k++) begin
      repeat (30) @(posedge clk);
      @(negedge clk);
      if (wdt_flag) seen = 1'b1;
      refresh = 1'b1;
      @(posedge clk);
      @(negedge clk);
      refresh = 1'b0;
    end
    // R3
    check(!seen && !wdt_flag, "R3 refresh prevents timeout", wdt_flag, 0);
  endtask

  task automatic t_reset_pulse();
    int n, hi;
    wr(1'b1, 8'd250);
    restart(1'b1);
    count_to_flag(500, n);
    check(n == 40, "R4 period with enable", n, 40);
    check(wdt_reset == 1'b1, "R4 pulse with flag", wdt_reset, 1);
    hi = 1;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); @(negedge clk);
      if (wdt_reset) hi++; else break;
    end
    check(hi == RL, "R4 pulse length", hi, RL);
    // R6
    check(wdt_flag == 1'b1, "R6 flag survives pulse", wdt_flag, 1);
    wr(1'b0, 8'h01);
    // R7
    check(wdt_flag == 1'b1, "R7 write 0 keeps flag", wdt_flag, 1);
    wr(1'b0, 8'h03);
    check(wdt_flag == 1'b0, "R7 write 1 clears flag", wdt_flag, 0);
    wr(1'b0, 8'h00);
  endtask

  task automatic t_idle();
    int n, m;
    wr(1'b1, 8'd250);
    restart(1'b0);
    n = 0;
    repeat (9) begin @(posedge clk); n++; end
    @(negedge clk);
    idle = 1'b1;
    @(posedge clk); n++;
    @(negedge clk);
    idle = 1'b0;
    repeat (49) begin @(posedge clk); n++; end
    @(negedge clk);
    // R8
    check(wdt_flag == 1'b0, "R8 no timeout while idle", wdt_flag, 0);
    wake = 1'b1;
    @(posedge clk); n++;
    @(negedge clk);
    wake = 1'b0;
    count_to_flag(500, m);
    check(n + m == 90, "R8 idle stretches period", n + m, 90);
  endtask

  task automatic t_midrun_reload();
    int n, m;
    wr(1'b1, 8'd250);
    restart(1'b0);
    repeat (5) @(posedge clk);
    wr(1'b1, 8'd200);
    count_to_flag(500, m);
    n = 5 + 1 + m;
    // R9
    check(n == 40, "R9 running count unaffected", n, 40);
    reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h02;
    count_to_flag(1000, m);
    // R10
    check(m == 440, "R10 restart uses new reload", m, 440);
  endtask

  task automatic t_por();
    check(wdt_flag == 1'b1, "R11 flag set before reset", wdt_flag, 1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R11
    check(wdt_flag == 1'b0, "R11 reset clears flag", wdt_flag, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_period(250);
    t_period(200);
    t_period(254);
    t_period(255);
    t_refresh_keeps();
    t_reset_pulse();
    t_idle();
    t_midrun_reload();
    t_por();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule